// File: doc/BRIEF.md
# Popcount-Compressed LFSR Signature Register

This block compresses a stream of bus samples into one 64-bit signature for built-in self-test. Each sample is a pair of operand words. The block XORs the pair, counts the ones in the result, and keeps that count modulo 2^CW, where CW = log2 of the operand width. For 64-bit operands this is a 6-bit value. On a valid sample, the value is XORed into the low bits of a free-running Fibonacci LFSR. The LFSR advances on every clock whether or not a sample arrives.

At the end of a test run the LFSR contents are the signature. The test controller pulses a check strobe and presents the expected signature. One cycle later a registered pass flag reports whether the two matched. The same state is also driven out as a weak pseudo-random word.

A build parameter removes the logic entirely. With `BIST_EN = 0`, no registers remain and every output is tied low.

The block has two state machines:

- **Update selector.** Each cycle it picks one of three actions:
  - `UPD_CLEAR`: load the seed.
  - `UPD_INJECT`: shift, then add the compressed count.
  - `UPD_SHIFT`: plain shift.
- **Check sequencer.** It has two states:
  - `CHK_RUN`: no check is pending. It moves to `CHK_REPORT` when the check strobe is high.
  - `CHK_REPORT`: the cycle in which a comparison result is shown. It returns to `CHK_RUN` when the strobe is low, and stays in `CHK_REPORT` while the strobe is held.

Top module: `popsig_compressor`

## Requirements
- R1: On a cycle with `valid_i` high and `clear_i` low, the next state equals the shifted state XORed in bits [CW-1:0] with popcount(`opa_i ^ opb_i`) mod 2^CW.
- R2: The count wraps modulo 2^CW, so an all-ones XOR result injects 0.
- R3: With `valid_i` low, operand values have no effect; the state takes a pure LFSR step.
- R4: Every cycle without clear, the state shifts toward the MSB. Bit 0 receives the XOR of state bits 63, 62, 60 and 59, which is the polynomial x^64+x^63+x^61+x^60+1.
- R5: `clear_i` high loads the seed 64'h1 at the next edge and overrides `valid_i`.
- R6: After reset the state is 64'h1 and `pass_o` is low.
- R7: If a step would produce all zeros, the seed 64'h1 is loaded instead, so the state is never zero.
- R8: `rnd_o` always equals `sig_o`.
- R9: `pass_o` is high for the cycle after a cycle in which `check_i` was high and `sig_o` equalled `expect_i`. Otherwise it is low.
- R10: With `BIST_EN = 0`, `sig_o`, `rnd_o` and `pass_o` are constantly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opa_i | input | DATA_W | First operand of the sample |
| opb_i | input | DATA_W | Second operand of the sample |
| valid_i | input | 1 | Sample strobe; enables injection |
| clear_i | input | 1 | Synchronous reload of the seed |
| check_i | input | 1 | Compare signature with `expect_i` |
| expect_i | input | LFSR_W | Expected signature |
| sig_o | output | LFSR_W | Signature (LFSR state) |
| rnd_o | output | LFSR_W | Pseudo-random word |
| pass_o | output | 1 | Registered match flag |

## Verification
The bench builds the block with `DATA_W = 8`, which makes the count three bits wide, and keeps the full 64-bit LFSR. It also builds a second copy with `BIST_EN = 0`.

The narrow operand width makes it possible to sweep all 256 XOR patterns from a known post-clear state. The expected value is computed arithmetically for each pattern. Within that sweep, the all-ones wrap falls out naturally. So does the one count (2) that cancels the shifted seed and triggers the zero-lock recovery.

A long run with mixed strobes and operands is then compared, cycle by cycle, against a polynomial model written from the requirements. The pass flag is exercised with both matching and mismatching expected values.

// File: rtl/popsig_pkg.sv
`timescale 1ns/1ps
package popsig_pkg;

    typedef enum logic [1:0] {
        UPD_SHIFT  = 2'd0,
        UPD_INJECT = 2'd1,
        UPD_CLEAR  = 2'd2
    } upd_e;

    typedef enum logic {
        CHK_RUN    = 1'b0,
        CHK_REPORT = 1'b1
    } chk_e;

    localparam logic [63:0] DEFAULT_TAPS = 64'hD800_0000_0000_0000;

endpackage

// File: rtl/popsig_count.sv
`timescale 1ns/1ps
module popsig_count #(
    parameter int DATA_W = 64,
    localparam int CW = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic [CW-1:0]     cnt_o
);

    logic [DATA_W-1:0] diff;
    logic [CW:0]       acc;

    assign diff = opa_i ^ opb_i;

    always_comb begin
        acc = '0;
        for (int i = 0; i < DATA_W; i++) begin
            acc = acc + (CW+1)'(diff[i]);
        end
    end

    // keep the low CW bits: the full count wraps to zero
    assign cnt_o = acc[CW-1:0];

endmodule

// File: rtl/popsig_lfsr.sv
`timescale 1ns/1ps
module popsig_lfsr
    import popsig_pkg::*;
#(
    parameter int               LFSR_W = 64,
    parameter int               CW     = 6,
    parameter logic [LFSR_W-1:0] TAPS  = LFSR_W'(DEFAULT_TAPS),
    parameter logic [LFSR_W-1:0] SEED  = LFSR_W'(1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              valid_i,
    input  logic              clear_i,
    input  logic [CW-1:0]     cnt_i,
    output logic [LFSR_W-1:0] state_o
);

    upd_e              mode;
    logic [LFSR_W-1:0] state_q;
    logic [LFSR_W-1:0] shifted;
    logic [LFSR_W-1:0] stepped;
    logic [LFSR_W-1:0] state_d;
    logic              fb;

    always_comb begin
        if (clear_i)      mode = UPD_CLEAR;
        else if (valid_i) mode = UPD_INJECT;
        else              mode = UPD_SHIFT;
    end

    assign fb      = ^(state_q & TAPS);
    assign shifted = {state_q[LFSR_W-2:0], fb};

    always_comb begin
        stepped = shifted;
        unique case (mode)
            UPD_CLEAR:  stepped = SEED;
            UPD_INJECT: stepped[CW-1:0] = shifted[CW-1:0] ^ cnt_i;
            UPD_SHIFT:  stepped = shifted;
            default:    stepped = SEED;
        endcase
    end

    // recover from the all-zero lock-up state
    assign state_d = (stepped == '0) ? SEED : stepped;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= SEED;
        else         state_q <= state_d;
    end

    assign state_o = state_q;

endmodule

// File: rtl/popsig_check.sv
`timescale 1ns/1ps
module popsig_check
    import popsig_pkg::*;
#(
    parameter int LFSR_W = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              check_i,
    input  logic [LFSR_W-1:0] sig_i,
    input  logic [LFSR_W-1:0] expect_i,
    output logic              pass_o
);

    chk_e st_q, st_d;
    logic pass_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= CHK_RUN;
        else         st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CHK_RUN:    st_d = check_i ? CHK_REPORT : CHK_RUN;
            CHK_REPORT: st_d = check_i ? CHK_REPORT : CHK_RUN;
            default:    st_d = CHK_RUN;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pass_q <= 1'b0;
        else         pass_q <= check_i && (sig_i == expect_i);
    end

    assign pass_o = (st_q == CHK_REPORT) && pass_q;

endmodule

// File: rtl/popsig_compressor.sv
`timescale 1ns/1ps
module popsig_compressor
    import popsig_pkg::*;
#(
    parameter int                BIST_EN = 1,
    parameter int                DATA_W  = 64,
    parameter int                LFSR_W  = 64,
    parameter logic [LFSR_W-1:0] TAPS    = LFSR_W'(DEFAULT_TAPS),
    parameter logic [LFSR_W-1:0] SEED    = LFSR_W'(1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic              valid_i,
    input  logic              clear_i,
    input  logic              check_i,
    input  logic [LFSR_W-1:0] expect_i,
    output logic [LFSR_W-1:0] sig_o,
    output logic [LFSR_W-1:0] rnd_o,
    output logic              pass_o
);

    localparam int CW = $clog2(DATA_W);

    generate
        if (BIST_EN != 0) begin : g_on
            logic [CW-1:0]     cnt;
            logic [LFSR_W-1:0] state;

            popsig_count #(.DATA_W(DATA_W)) u_count (
                .opa_i (opa_i),
                .opb_i (opb_i),
                .cnt_o (cnt)
            );

            popsig_lfsr #(
                .LFSR_W (LFSR_W),
                .CW     (CW),
                .TAPS   (TAPS),
                .SEED   (SEED)
            ) u_lfsr (
                .clk_i   (clk_i),
                .rst_ni  (rst_ni),
                .valid_i (valid_i),
                .clear_i (clear_i),
                .cnt_i   (cnt),
                .state_o (state)
            );

            popsig_check #(.LFSR_W(LFSR_W)) u_check (
                .clk_i    (clk_i),
                .rst_ni   (rst_ni),
                .check_i  (check_i),
                .sig_i    (state),
                .expect_i (expect_i),
                .pass_o   (pass_o)
            );

            assign sig_o = state;
            assign rnd_o = state;
        end else begin : g_off
            assign sig_o  = '0;
            assign rnd_o  = '0;
            assign pass_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/popsig_props.sv
`timescale 1ns/1ps
module popsig_props #(
    parameter int                BIST_EN = 1,
    parameter int                DATA_W  = 64,
    parameter int                LFSR_W  = 64,
    parameter logic [LFSR_W-1:0] SEED    = LFSR_W'(1)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              valid_i,
    input logic              clear_i,
    input logic              check_i,
    input logic [DATA_W-1:0] opa_i,
    input logic [DATA_W-1:0] opb_i,
    input logic [LFSR_W-1:0] expect_i,
    input logic [LFSR_W-1:0] sig_o,
    input logic [LFSR_W-1:0] rnd_o,
    input logic              pass_o
);

    localparam int CW = $clog2(DATA_W);

    logic armed;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) armed <= 1'b0;
        else         armed <= 1'b1;
    end

    logic unused_ops;
    assign unused_ops = ^{opa_i, opb_i};

    generate
        if (BIST_EN != 0) begin : g_chk
            assert_shift_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (armed && $past(!clear_i)) |-> sig_o[LFSR_W-1:CW] == $past(sig_o[LFSR_W-2:CW-1]));

            assert_noinject_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (armed && $past(!clear_i && !valid_i)) |-> sig_o[CW-1:1] == $past(sig_o[CW-2:0]));

            assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (armed && $past(clear_i)) |-> sig_o == SEED);

            assert_nonzero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
                sig_o != '0);

            assert_rnd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
                rnd_o == sig_o);

            assert_pass_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (armed && pass_o) |-> $past(check_i && sig_o == expect_i));

            assert_pass_hit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (armed && $past(check_i && sig_o == expect_i)) |-> pass_o);
        end else begin : g_off
            assert_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (sig_o == '0 && rnd_o == '0 && !pass_o && (armed || !armed)));
        end
    endgenerate

endmodule

bind popsig_compressor popsig_props #(
    .BIST_EN (BIST_EN),
    .DATA_W  (DATA_W),
    .LFSR_W  (LFSR_W),
    .SEED    (SEED)
) u_props (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .clear_i  (clear_i),
    .check_i  (check_i),
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .expect_i (expect_i),
    .sig_o    (sig_o),
    .rnd_o    (rnd_o),
    .pass_o   (pass_o)
);

// File: tb/sim_popsig_compressor.sv
`timescale 1ns/1ps
module sim_popsig_compressor;

    localparam int DW = 8;
    localparam int LW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] opa = '0, opb = '0;
    logic          valid = 1'b0, clear = 1'b0, check = 1'b0;
    logic [LW-1:0] expv = '0;
    logic [LW-1:0] sig, rnd, sig_off, rnd_off;
    logic          pass, pass_off;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    popsig_compressor #(.BIST_EN(1), .DATA_W(DW), .LFSR_W(LW)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .opa_i(opa), .opb_i(opb),
        .valid_i(valid), .clear_i(clear), .check_i(check), .expect_i(expv),
        .sig_o(sig), .rnd_o(rnd), .pass_o(pass));

    popsig_compressor #(.BIST_EN(0), .DATA_W(DW), .LFSR_W(LW)) u_off (
        .clk_i(clk), .rst_ni(rst_n), .opa_i(opa), .opb_i(opb),
        .valid_i(valid), .clear_i(clear), .check_i(check), .expect_i(expv),
        .sig_o(sig_off), .rnd_o(rnd_off), .pass_o(pass_off));

    function automatic logic [2:0] pc3(input logic [DW-1:0] x);
        int c = 0;
        for (int i = 0; i < DW; i++) c += int'(x[i]);
        return 3'(c % 8);
    endfunction

    function automatic logic [LW-1:0] model(input logic [LW-1:0] s, input bit v,
                                            input bit clr, input logic [DW-1:0] a,
                                            input logic [DW-1:0] b);
        logic [LW-1:0] n;
        if (clr) return 64'h1;
        n = {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
        if (v) n[2:0] = n[2:0] ^ pc3(a ^ b);
        if (n == '0) n = 64'h1;
        return n;
    endfunction

    task automatic chk(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=<100000", cyc);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        logic [LW-1:0] m;
        logic [LW-1:0] e;
        logic [DW-1:0] x;
        int unsigned lcg = 32'h1234_5678;

        repeat (3) step();
        // R6 reset state, R10 disabled copy
        chk("R6 sig", sig, 64'h1);
        chk("R6 pass", {63'd0, pass}, 64'd0);
        chk("R10 off", sig_off | rnd_off | {63'd0, pass_off}, 64'd0);
        rst_n = 1'b1;

        // R1/R2/R7 sweep every XOR pattern from the post-clear state
        for (int i = 0; i < 256; i++) begin
            clear = 1'b1; valid = 1'b0;
            step();
            chk("R5 clear", sig, 64'h1);
            clear = 1'b0; valid = 1'b1;
            opa = 8'(i); opb = 8'((i * 37 + 11) & 255);
            x = opa ^ opb;
            step();
            e = 64'h2 ^ {61'd0, pc3(x)};
            if (e == '0) begin
                e = 64'h1;
                chk("R7 lockup", sig, e);
            end else if (x == 8'hFF) chk("R2 wrap", sig, e);
            else chk("R1 inject", sig, e);
        end
        // direct R2 and R7 corner cases
        clear = 1'b1; valid = 1'b0; step();
        clear = 1'b0; valid = 1'b1; opa = 8'hFF; opb = 8'h00; step();
        chk("R2 all-ones", sig, 64'h2);
        clear = 1'b1; valid = 1'b0; step();
        clear = 1'b0; valid = 1'b1; opa = 8'h03; opb = 8'h00; step();
        chk("R7 zero->seed", sig, 64'h1);

        // R5 clear overrides valid
        clear = 1'b1; valid = 1'b1; opa = 8'h0F; opb = 8'h00; step();
        chk("R5 priority", sig, 64'h1);
        clear = 1'b0; valid = 1'b0;

        // R3/R4/R8 long mixed run against the polynomial model
        m = sig;
        for (int k = 0; k < 3000; k++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            valid = lcg[20];
            clear = (lcg[31:24] == 8'h00);
            opa = lcg[15:8];
            opb = lcg[27:20];
            m = model(m, valid, clear, opa, opb);
            step();
            if (clear) chk("R5 run", sig, m);
            else if (valid) chk("R4 R1 run", sig, m);
            else chk("R3 R4 run", sig, m);
            chk("R8 rnd", rnd, sig);
            if (k % 500 == 0) chk("R10 off run", sig_off | rnd_off | {63'd0, pass_off}, 64'd0);
        end
        clear = 1'b0; valid = 1'b0;

        // R9 pass flag
        check = 1'b1; expv = sig; step();
        chk("R9 match", {63'd0, pass}, 64'd1);
        check = 1'b0; step();
        chk("R9 one-shot", {63'd0, pass}, 64'd0);
        check = 1'b1; expv = sig ^ 64'h8000_0000_0000_0000; step();
        chk("R9 mismatch", {63'd0, pass}, 64'd0);
        check = 1'b0; step();
        chk("R9 idle", {63'd0, pass}, 64'd0);
        chk("R10 pass off", {63'd0, pass_off}, 64'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule